// File: doc/BRIEF.md
# Fuse Array Controller with Program Unlock

This block lets a CPU read and burn a one-time-programmable fuse array through a small register bus. Software enables CPU access in a mode register, picks an operation code, sets a word address and, for burns, a data word. It then raises a start bit and polls a status register until the operation reports done. Writing the start bit back to 0 clears done and readies the block for the next operation.

Burning is locked after reset. To unlock it, software issues four arm operations, each carrying one key value in the write-data register, and each with its own start/done handshake. The lock opens only when all four keys arrive in order. A disarm operation locks the array again. The fuse array only accumulates ones: a burn ORs its data into the addressed word.

Burn time grows with the number of one bits in the data word. Burn time is a fixed base plus a fixed cost per set bit. Reads and the lock operations take fixed times.

Top module: `fuse_ctrl`

## Requirements
- R1: The register map uses these byte offsets. Mode is at 0x00, with its enable in bit 0. Operation is at 0x04 and is 6 bits wide. Start is at 0x08 (bit 0). Status is at 0x0C. Read data is at 0x10. Address is at 0x28 and is 16 bits wide. Write data is at 0x2C and is 32 bits wide. On readback, bits above each field's width read as 0. After reset every register reads 0.
- R2: While mode bit 0 is 0, a start write launches nothing, and status done (bit 1) stays 0.
- R3: An operation launches on a write of 1 to start bit 0 while start holds 0. Done (status bit 1) rises when the operation completes. Done stays set until a write of 0 to start bit 0 clears it.
- R4: The read operation (code 0x00) takes READ_CYC cycles, counted from the start-write edge to done. When done is set, the read-data register holds the word at the address.
- R5: The arm operation (code 0x02) takes CTRL_CYC cycles. Four arms whose write data is 0xF, 0x4, 0x8 and 0xD, in that order, set status bit 2 (armed). Armed is set only after the fourth arm completes.
- R6: An arm whose write data does not match the expected key resets the key sequence to its first value. The full four-key sequence is then needed again.
- R7: A burn operation (code 0x0A) issued while not armed still completes with done, but it leaves the array unchanged.
- R8: A burn while armed ORs the write data into the addressed word. Fuse bits never return from 1 to 0.
- R9: A burn takes BASE_CYC + PER_BIT_CYC × (number of ones in the write data) cycles, counted from the start-write edge to done.
- R10: The disarm operation (code 0x03) takes CTRL_CYC cycles and clears armed. Burns after a disarm leave the array unchanged.
- R11: The array word is selected by the low log2(ARRAY_WORDS) bits of the address register. Any other operation code completes in CTRL_CYC cycles and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when 1 |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest states to reach from the ports are partial key sequences, where a wrong value lands at the second, third or fourth step. Another is a burn that meets a word already holding ones, where the OR and not an overwrite has to show. The stimulus covers these with a few directed key runs that break at a chosen step. Random operations then follow: arm steps that carry the correct next key half the time, sparse random burns to random addresses, and occasional disarms. A bench model tracks the key position, the armed flag and every fuse word, and uses them to predict read data, status and cycle counts.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int WORD_W  = 32;
  localparam int OP_W    = 6;
  localparam int ADDR_W  = 16;
  localparam int REG_AW  = 6;
  localparam int KEY_LEN = 4;

  localparam logic [OP_W-1:0] OP_READ   = 6'h00;
  localparam logic [OP_W-1:0] OP_ARM    = 6'h02;
  localparam logic [OP_W-1:0] OP_DISARM = 6'h03;
  localparam logic [OP_W-1:0] OP_BURN   = 6'h0A;

  localparam logic [REG_AW-1:0] OFS_MODE  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_OP    = 6'h04;
  localparam logic [REG_AW-1:0] OFS_GO    = 6'h08;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_RDATA = 6'h10;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 6'h28;
  localparam logic [REG_AW-1:0] OFS_WDATA = 6'h2C;

  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_ARMED_BIT = 2;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_t;

  // Expected key for each step of the arm sequence
  function automatic logic [WORD_W-1:0] arm_key(input logic [1:0] step);
    case (step)
      2'd0:    arm_key = 32'h0000_000F;
      2'd1:    arm_key = 32'h0000_0004;
      2'd2:    arm_key = 32'h0000_0008;
      default: arm_key = 32'h0000_000D;
    endcase
  endfunction

  function automatic int ones_in(input logic [WORD_W-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
    return n;
  endfunction

  // Cycles from start-write edge to done for one operation
  function automatic int op_cycles(input logic [OP_W-1:0] op, input logic [WORD_W-1:0] w,
                                   input int base, input int per_bit,
                                   input int rd, input int ctrl);
    case (op)
      OP_READ: return rd;
      OP_BURN: return base + per_bit * ones_in(w);
      default: return ctrl;
    endcase
  endfunction
endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              seq_idle_i,
  input  logic              op_done_i,
  input  logic              armed_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              mode_en_o,
  output logic [OP_W-1:0]   op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              launch_o
);
  logic              mode_q, go_q, done_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  // Named bus events
  logic wr_any, go_set, go_clr;
  assign wr_any   = bus_sel && bus_wr;
  assign go_set   = wr_any && (bus_addr == OFS_GO) && bus_wdata[0];
  assign go_clr   = wr_any && (bus_addr == OFS_GO) && !bus_wdata[0];
  assign launch_o = go_set && !go_q && mode_q && seq_idle_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      go_q    <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (wr_any && bus_addr == OFS_MODE)  mode_q  <= bus_wdata[0];
      if (wr_any && bus_addr == OFS_OP)    op_q    <= bus_wdata[OP_W-1:0];
      if (wr_any && bus_addr == OFS_ADDR)  addr_q  <= bus_wdata[ADDR_W-1:0];
      if (wr_any && bus_addr == OFS_WDATA) wdata_q <= bus_wdata;
      if (go_set) go_q <= 1'b1;
      else if (go_clr) go_q <= 1'b0;
      if (go_clr) done_q <= 1'b0;
      else if (op_done_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE:  bus_rdata = WORD_W'(mode_q);
      OFS_OP:    bus_rdata = WORD_W'(op_q);
      OFS_GO:    bus_rdata = WORD_W'(go_q);
      OFS_STAT: begin
        bus_rdata[STAT_DONE_BIT]  = done_q;
        bus_rdata[STAT_ARMED_BIT] = armed_i;
      end
      OFS_RDATA: bus_rdata = rdata_i;
      OFS_ADDR:  bus_rdata = WORD_W'(addr_q);
      OFS_WDATA: bus_rdata = wdata_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign mode_en_o = mode_q;
  assign op_o      = op_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;

  AST_DONE_CLEARS_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(go_clr)); // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !go_clr) |=> done_q); // R3
endmodule

// File: rtl/fuse_unlock.sv
module fuse_unlock
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done_i,
  input  logic [OP_W-1:0]   op_cmd_i,
  input  logic [WORD_W-1:0] op_data_i,
  output logic              armed_o
);
  localparam int STEP_W = $clog2(KEY_LEN);

  logic [STEP_W-1:0] step_q;
  logic              armed_q;

  logic arm_evt, disarm_evt, key_hit, last_step;
  assign arm_evt    = op_done_i && (op_cmd_i == OP_ARM);
  assign disarm_evt = op_done_i && (op_cmd_i == OP_DISARM);
  assign key_hit    = (op_data_i == arm_key(2'(step_q)));
  assign last_step  = (step_q == STEP_W'(KEY_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= '0;
      armed_q <= 1'b0;
    end else if (disarm_evt) begin
      step_q  <= '0;
      armed_q <= 1'b0;
    end else if (arm_evt) begin
      if (!key_hit) begin
        step_q <= '0;
      end else if (last_step) begin
        step_q  <= '0;
        armed_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign armed_o = armed_q;

  AST_ARMED_AFTER_FINAL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(arm_evt) && $past(last_step) && $past(key_hit))); // R5
  AST_WRONG_KEY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_evt && !key_hit) |=> (step_q == '0)); // R6
  AST_DISARM_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_evt |=> !armed_q); // R10
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int BASE_CYC    = 4,
  parameter int PER_BIT_CYC = 2,
  parameter int READ_CYC    = 3,
  parameter int CTRL_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              mode_en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              armed_i,
  output logic              idle_o,
  output logic              op_done_o,
  output logic [OP_W-1:0]   op_cmd_o,
  output logic [IDX_W-1:0]  op_idx_o,
  output logic [WORD_W-1:0] op_data_o,
  output logic              burn_o,
  output logic              fetch_o
);
  localparam int MAX_CYC = BASE_CYC + PER_BIT_CYC * WORD_W + READ_CYC + CTRL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q, load_cnt;
  logic [OP_W-1:0]   cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] data_q;

  assign load_cnt = CNT_W'(op_cycles(op_i, data_i, BASE_CYC, PER_BIT_CYC, READ_CYC, CTRL_CYC) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (launch_i) begin
        state_q <= SEQ_BUSY;
        cnt_q   <= load_cnt;
        cmd_q   <= op_i;
        idx_q   <= idx_i;
        data_q  <= data_i;
      end
    end else if (cnt_q == '0) begin
      state_q <= SEQ_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idle_o    = (state_q == SEQ_IDLE);
  assign op_done_o = (state_q == SEQ_BUSY) && (cnt_q == '0);
  assign op_cmd_o  = cmd_q;
  assign op_idx_o  = idx_q;
  assign op_data_o = data_q;
  assign burn_o    = op_done_o && (cmd_q == OP_BURN) && armed_i;
  assign fetch_o   = op_done_o && (cmd_q == OP_READ);

  AST_MODE_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && !mode_en_i) |=> (state_q == SEQ_IDLE)); // R2
  AST_COUNT_DOWN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_BUSY && cnt_q != '0) |=> (state_q == SEQ_BUSY && cnt_q == $past(cnt_q) - 1'b1)); // R9
  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_BUSY && cnt_q != '0) |=> ($stable(cmd_q) && $stable(data_q) && $stable(idx_q))); // R4
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burn_i,
  input  logic              fetch_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] cur_word;

  assign cur_word = mem_q[idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (burn_i)  mem_q[idx_i] <= cur_word | data_i;
      if (fetch_i) rdata_q <= cur_word;
    end
  end

  assign rdata_o = rdata_q;

  AST_FUSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    burn_i |=> ((mem_q[$past(idx_i)] & $past(cur_word)) == $past(cur_word))); // R8
  AST_FETCH_RETURNS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_i |=> (rdata_q == $past(cur_word))); // R4
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int ARRAY_WORDS = 64,
  parameter int BASE_CYC    = 4,
  parameter int PER_BIT_CYC = 2,
  parameter int READ_CYC    = 3,
  parameter int CTRL_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int IDX_W = (ARRAY_WORDS > 1) ? $clog2(ARRAY_WORDS) : 1;

  logic              mode_en, launch, seq_idle, op_done, armed, burn, fetch;
  logic [OP_W-1:0]   op_sel, op_cmd;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata, op_data, rdata;
  logic [IDX_W-1:0]  op_idx;

  fuse_regs u_regs (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .seq_idle_i(seq_idle), .op_done_i(op_done), .armed_i(armed), .rdata_i(rdata),
    .mode_en_o(mode_en), .op_o(op_sel), .addr_o(addr), .wdata_o(wdata), .launch_o(launch)
  );

  fuse_seq #(
    .IDX_W(IDX_W), .BASE_CYC(BASE_CYC), .PER_BIT_CYC(PER_BIT_CYC),
    .READ_CYC(READ_CYC), .CTRL_CYC(CTRL_CYC)
  ) u_seq (
    .clk, .rst_n, .launch_i(launch), .mode_en_i(mode_en), .op_i(op_sel),
    .idx_i(addr[IDX_W-1:0]), .data_i(wdata), .armed_i(armed),
    .idle_o(seq_idle), .op_done_o(op_done), .op_cmd_o(op_cmd), .op_idx_o(op_idx),
    .op_data_o(op_data), .burn_o(burn), .fetch_o(fetch)
  );

  fuse_unlock u_unlock (
    .clk, .rst_n, .op_done_i(op_done), .op_cmd_i(op_cmd), .op_data_i(op_data),
    .armed_o(armed)
  );

  fuse_array #(.WORDS(ARRAY_WORDS), .IDX_W(IDX_W)) u_array (
    .clk, .rst_n, .burn_i(burn), .fetch_i(fetch), .idx_i(op_idx), .data_i(op_data),
    .rdata_o(rdata)
  );

  AST_LOCKED_NO_BURN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_cmd == OP_BURN && !armed) |-> !burn); // R7
endmodule

// File: tb/fuse_ctrl_tb_top.sv
module fuse_ctrl_tb_top;
  localparam logic [5:0] A_MODE = 6'h00, A_OP = 6'h04, A_GO = 6'h08, A_STAT = 6'h0C;
  localparam logic [5:0] A_RD = 6'h10, A_ADDR = 6'h28, A_WD = 6'h2C;
  localparam logic [5:0] C_RD = 6'h00, C_ARM = 6'h02, C_DIS = 6'h03, C_BURN = 6'h0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_mem [64];
  bit          m_armed = 0;
  int          m_step = 0;
  logic [31:0] keys [4] = '{32'hF, 32'h4, 32'h8, 32'hD};

  always #4 clk = ~clk;

  fuse_ctrl dut_i (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata);

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic int bits_set(input logic [31:0] v);
    int c = 0;
    while (v != 0) begin v = v & (v - 1); c++; end
    return c;
  endfunction

  function automatic int want_cycles(input logic [5:0] op, input logic [31:0] d);
    if (op == C_RD) return 3;
    if (op == C_BURN) return 4 + bits_set(d) * 2;
    return 2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  // Launch an operation, count cycles until done (or limit), leave start set
  task automatic launch(input logic [5:0] op, input logic [15:0] a, input logic [31:0] d,
                        input int limit, output int cyc);
    wr(A_OP, 32'(op)); wr(A_ADDR, 32'(a)); wr(A_WD, d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_GO; bus_wdata = 32'h1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; bus_addr = A_STAT; #1;
    cyc = 0;
    while (!bus_rdata[1] && cyc < limit) begin @(negedge clk); #1; cyc++; end
  endtask

  // Full operation with model update and checks
  task automatic do_op(input logic [5:0] op, input logic [15:0] a, input logic [31:0] d,
                       input string req);
    int cyc;
    logic [31:0] v;
    launch(op, a, d, 200, cyc);
    check({req, " cycles to done"}, 32'(cyc), 32'(want_cycles(op, d)));
    case (op)
      C_RD: begin
        rd(A_RD, v);
        check({req, " read data"}, v, m_mem[a[5:0]]);
      end
      C_BURN: if (m_armed) m_mem[a[5:0]] = m_mem[a[5:0]] | d;
      C_ARM: begin
        if (d == keys[m_step]) begin
          if (m_step == 3) begin m_armed = 1; m_step = 0; end
          else m_step++;
        end else m_step = 0;
      end
      C_DIS: begin m_armed = 0; m_step = 0; end
      default: ;
    endcase
    rd(A_STAT, v);
    check({req, " armed flag"}, 32'(v[2]), 32'(m_armed));
    wr(A_GO, 32'h0);
    rd(A_STAT, v);
    check("R3 done cleared by start=0", 32'(v[1]), 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    int cyc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state and readback masking
    rd(A_STAT, v);  check("R1 reset status", v, 32'h0);
    rd(A_MODE, v);  check("R1 reset mode", v, 32'h0);
    rd(A_RD, v);    check("R1 reset read data", v, 32'h0);
    rd(A_ADDR, v);  check("R1 reset address", v, 32'h0);
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, v); check("R1 mode readback", v, 32'h1);
    wr(A_OP, 32'hFFFF_FFFF);   rd(A_OP, v);   check("R1 op field 6 bits", v, 32'h3F);
    wr(A_ADDR, 32'hABCD_1234); rd(A_ADDR, v); check("R1 address 16 bits", v, 32'h1234);
    wr(A_WD, 32'hDEAD_BEEF);   rd(A_WD, v);   check("R1 write data", v, 32'hDEAD_BEEF);

    // R2 access disabled: no launch
    wr(A_MODE, 32'h0);
    launch(C_RD, 16'h5, 32'h0, 20, cyc);
    rd(A_STAT, v); check("R2 no done while mode off", 32'(v[1]), 32'h0);
    wr(A_GO, 32'h0);
    wr(A_MODE, 32'h1);

    // R3/R4 read of blank word
    launch(C_RD, 16'h5, 32'h0, 200, cyc);
    check("R4 read latency", 32'(cyc), 32'h3);
    rd(A_STAT, v); check("R3 done set after launch", 32'(v[1]), 32'h1);
    wr(A_GO, 32'h0);
    rd(A_STAT, v); check("R3 done cleared", 32'(v[1]), 32'h0);

    // R7 burn while locked
    do_op(C_BURN, 16'h7, 32'h0000_FFFF, "R7");
    do_op(C_RD, 16'h7, 32'h0, "R7");

    // R6 wrong key at third step, then remaining keys do not unlock
    do_op(C_ARM, 16'h0, 32'hF, "R6");
    do_op(C_ARM, 16'h0, 32'h4, "R6");
    do_op(C_ARM, 16'h0, 32'h9, "R6");
    do_op(C_ARM, 16'h0, 32'h8, "R6");
    do_op(C_ARM, 16'h0, 32'hD, "R6");
    // wrong key at the last step
    do_op(C_ARM, 16'h0, 32'hF, "R6");
    do_op(C_ARM, 16'h0, 32'h4, "R6");
    do_op(C_ARM, 16'h0, 32'h8, "R6");
    do_op(C_ARM, 16'h0, 32'hE, "R6");
    rd(A_STAT, v); check("R6 still locked", 32'(v[2]), 32'h0);

    // R5 correct sequence
    do_op(C_ARM, 16'h0, 32'hF, "R5");
    do_op(C_ARM, 16'h0, 32'h4, "R5");
    do_op(C_ARM, 16'h0, 32'h8, "R5");
    rd(A_STAT, v); check("R5 not armed before fourth key", 32'(v[2]), 32'h0);
    do_op(C_ARM, 16'h0, 32'hD, "R5");
    rd(A_STAT, v); check("R5 armed after fourth key", 32'(v[2]), 32'h1);

    // R8 OR accumulation
    do_op(C_BURN, 16'h7, 32'h0000_00F0, "R8");
    do_op(C_BURN, 16'h7, 32'h0000_0F0F, "R8");
    do_op(C_RD, 16'h7, 32'h0, "R8");
    rd(A_RD, v); check("R8 accumulated word", v, 32'h0000_0FFF);
    do_op(C_BURN, 16'h7, 32'h0, "R8");
    do_op(C_RD, 16'h7, 32'h0, "R8");

    // R9 timing extremes
    do_op(C_BURN, 16'h9, 32'hFFFF_FFFF, "R9");
    do_op(C_BURN, 16'hA, 32'h0, "R9");

    // R11 address aliasing and unknown op
    do_op(C_BURN, 16'hFFC9, 32'h0001_0000, "R11");
    do_op(C_RD, 16'h0009, 32'h0, "R11");
    do_op(6'h15, 16'h9, 32'h0, "R11");

    // R10 disarm then burn has no effect
    do_op(C_DIS, 16'h0, 32'h0, "R10");
    do_op(C_BURN, 16'h7, 32'hF000_0000, "R10");
    do_op(C_RD, 16'h7, 32'h0, "R10");

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      int sel;
      logic [15:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      a = 16'($urandom);
      if (sel <= 2) do_op(C_RD, a, 32'h0, "R4");
      else if (sel <= 5) begin
        d = $urandom & $urandom & $urandom;
        do_op(C_BURN, a, d, m_armed ? "R8" : "R7");
      end else if (sel <= 8) begin
        d = ($urandom_range(0, 1) == 1) ? keys[m_step] : 32'($urandom_range(0, 15));
        do_op(C_ARM, a, d, "R6");
      end else do_op(C_DIS, a, 32'h0, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule